// File: doc/BRIEF.md
# Programmable Occupancy Threshold Flags

This block produces the almost-empty, almost-full and half-full warnings for a FIFO. It does not hold any data. The read side of the FIFO gives it the occupancy that the read side sees, and the write side gives it the occupancy that the write side sees. From these counts and two programmable margins, one for the empty end and one for the full end, the block raises the flags early enough for the producer and consumer to throttle before the buffer hits a hard limit.

Both margins start from a preset. During master reset a 3-bit selector picks one of eight preset values, and both margins load that value. After reset, software can reprogram the margins in one of two ways. It can write them as whole words on a parallel bus, or it can shift them in one bit per clock on a serial line. A load strobe qualifies both methods, and the serial enable chooses between them. Partial reset keeps the programmed margins. A mode pin is also sampled during master reset. It sets whether the flags come from registers, with the almost-empty flag on the read clock and the other two on the write clock, or whether they follow the counts combinationally.

Top module: `occ_flag_top`

## Requirements
- R1: While master reset `mrst` is high, both margins load the preset value 2^(presetSel+1)-1. With the 8-bit default margins, presetSel=0 gives 1, presetSel=3 gives 15 and presetSel=7 gives 255.
- R2: Almost-empty `almostEmpty` is 1 exactly when rdLevel is less than or equal to the empty margin.
- R3: Almost-full `almostFull` is 1 exactly when the free space DEPTH-wrLevel is less than or equal to the full margin.
- R4: Half-full `halfFull` is 1 exactly when wrLevel is greater than DEPTH/2. With DEPTH=256, a level of 128 gives 0 and a level of 129 gives 1.
- R5: In registered mode (asyncMode low during master reset), each flag shows the value computed from the levels at the previous rising edge of its clock. During master reset or partial reset the flags hold almostEmpty=1, almostFull=0, halfFull=0.
- R6: In combinational mode (asyncMode high during master reset), the flags follow the levels with no clock edge in between. The mode is captured only while `mrst` is high.
- R7: A parallel write happens on a wrClk edge with loadEn=1 and serEn=0. The first such write stores parData into the empty margin and the next one stores it into the full margin, and the two alternate from then on.
- R8: A serial shift happens on a wrClk edge with loadEn=1 and serEn=1. Each shift takes in one bit of serIn. A complete load is 2*OFF_W shifts: the empty margin comes first, least significant bit first, then the full margin in the same bit order.
- R9: Partial reset `prst` keeps both margins. It returns the parallel-write sequence so that the next parallel write goes to the empty margin.
- R10: While loadEn=0, serEn, serIn and parData have no effect on either margin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock; also clocks the margins and the load logic |
| rdClk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| presetSel | input | 3 | Preset selector, sampled during master reset |
| asyncMode | input | 1 | 1 selects combinational flags; sampled during master reset |
| rdLevel | input | CNT_W (9) | Occupancy as seen by the read side |
| wrLevel | input | CNT_W (9) | Occupancy as seen by the write side |
| loadEn | input | 1 | Load strobe that qualifies every margin write |
| serEn | input | 1 | 1 selects serial shifting, 0 selects parallel writes |
| serIn | input | 1 | Serial margin data |
| parData | input | OFF_W (8) | Parallel margin data |
| almostEmpty | output | 1 | Occupancy at or below the empty margin |
| almostFull | output | 1 | Free space at or below the full margin |
| halfFull | output | 1 | Occupancy above half the depth |

## Verification
The comparators are checked with levels placed on both sides of every threshold: margin and margin+1 for almost-empty, free space equal to the margin and one above it for almost-full, and 128 and 129 for half-full. Each pair separates a "less than" comparison from a "less than or equal" comparison. The same pairs are repeated after a preset load, a parallel load, a serial load and a partial reset, each with different margins, so a swapped register, a reversed bit order or a lost margin moves a threshold to a value the bench can see. In registered mode the bench samples one edge after each level change. In combinational mode it samples before any edge, which separates the two timing options.

// File: rtl/occ_flag_pkg.sv
package occ_flag_pkg;
  // Strobes from the load control to the margin datapath
  typedef struct packed {
    logic presetLoad;  // load preset into both margins
    logic serShift;    // shift one serial bit
    logic parEmpty;    // parallel write to empty margin
    logic parFull;     // parallel write to full margin
  } offStrobe_t;
endpackage

// File: rtl/occ_flag_ctrl.sv
module occ_flag_ctrl
  import occ_flag_pkg::*;
(
  input  logic       wrClk,
  input  logic       mrst,
  input  logic       prst,
  input  logic       loadEn,
  input  logic       serEn,
  output offStrobe_t stb
);
  logic parSelQ;  // 0: next parallel write goes to empty margin
  logic parWrite;

  assign parWrite = loadEn && !serEn && !mrst;

  always_ff @(posedge wrClk) begin
    if (mrst || prst) parSelQ <= 1'b0;
    else if (parWrite) parSelQ <= ~parSelQ;
  end

  always_comb begin
    stb.presetLoad = mrst;
    stb.serShift   = loadEn && serEn && !mrst;
    stb.parEmpty   = parWrite && !parSelQ;
    stb.parFull    = parWrite && parSelQ;
  end
endmodule

// File: rtl/occ_flag_dp.sv
module occ_flag_dp
  import occ_flag_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int OFF_W = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             mrst,
  input  logic             prst,
  input  offStrobe_t       stb,
  input  logic [2:0]       presetSel,
  input  logic             asyncMode,
  input  logic [CNT_W-1:0] rdLevel,
  input  logic [CNT_W-1:0] wrLevel,
  input  logic             serIn,
  input  logic [OFF_W-1:0] parData,
  output logic             almostEmpty,
  output logic             almostFull,
  output logic             halfFull
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(DEPTH / 2);

  logic [OFF_W-1:0] emptyOff, fullOff, presetVal;
  logic [CNT_W-1:0] freeCnt;
  logic             asyncQ;
  logic             aeNext, afNext, hfNext;
  logic             aeQ, afQ, hfQ;

  // Preset: 2^(sel+1)-1, saturating at the margin width
  always_comb begin
    presetVal = '1;
    for (int i = 0; i < 8; i++)
      if (presetSel == 3'(i) && (i + 1) < OFF_W)
        presetVal = OFF_W'((1 << (i + 1)) - 1);
  end

  always_ff @(posedge wrClk) begin
    if (stb.presetLoad) begin
      emptyOff <= presetVal;
      fullOff  <= presetVal;
    end else if (stb.serShift) begin
      {fullOff, emptyOff} <= {serIn, fullOff, emptyOff[OFF_W-1:1]};
    end else if (stb.parEmpty) begin
      emptyOff <= parData;
    end else if (stb.parFull) begin
      fullOff <= parData;
    end
  end

  always_ff @(posedge wrClk) begin
    if (mrst) asyncQ <= asyncMode;
  end

  assign freeCnt = DEPTH_C - wrLevel;
  assign aeNext  = rdLevel <= CNT_W'(emptyOff);
  assign afNext  = freeCnt <= CNT_W'(fullOff);
  assign hfNext  = wrLevel > HALF_C;

  always_ff @(posedge rdClk) begin
    if (mrst || prst) aeQ <= 1'b1;
    else aeQ <= aeNext;
  end

  always_ff @(posedge wrClk) begin
    if (mrst || prst) begin
      afQ <= 1'b0;
      hfQ <= 1'b0;
    end else begin
      afQ <= afNext;
      hfQ <= hfNext;
    end
  end

  assign almostEmpty = asyncQ ? aeNext : aeQ;
  assign almostFull  = asyncQ ? afNext : afQ;
  assign halfFull    = asyncQ ? hfNext : hfQ;
endmodule

// File: rtl/occ_flag_top.sv
module occ_flag_top
  import occ_flag_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int OFF_W = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             mrst,
  input  logic             prst,
  input  logic [2:0]       presetSel,
  input  logic             asyncMode,
  input  logic [CNT_W-1:0] rdLevel,
  input  logic [CNT_W-1:0] wrLevel,
  input  logic             loadEn,
  input  logic             serEn,
  input  logic             serIn,
  input  logic [OFF_W-1:0] parData,
  output logic             almostEmpty,
  output logic             almostFull,
  output logic             halfFull
);
  offStrobe_t stb;

  occ_flag_ctrl i_ctrl (
    .wrClk(wrClk), .mrst(mrst), .prst(prst),
    .loadEn(loadEn), .serEn(serEn), .stb(stb)
  );

  occ_flag_dp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OFF_W(OFF_W)) i_dp (
    .wrClk(wrClk), .rdClk(rdClk), .mrst(mrst), .prst(prst), .stb(stb),
    .presetSel(presetSel), .asyncMode(asyncMode),
    .rdLevel(rdLevel), .wrLevel(wrLevel), .serIn(serIn), .parData(parData),
    .almostEmpty(almostEmpty), .almostFull(almostFull), .halfFull(halfFull)
  );
endmodule

// File: rtl/occ_flag_chk.sv
module occ_flag_chk #(
  parameter int DEPTH = 256,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             mrst,
  input logic             prst,
  input logic             asyncMode,
  input logic [CNT_W-1:0] rdLevel,
  input logic [CNT_W-1:0] wrLevel,
  input logic             almostEmpty,
  input logic             almostFull,
  input logic             halfFull
);
  localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic modeSeen, armedWr, armedRd;

  always_ff @(posedge wrClk) begin
    if (mrst) modeSeen <= asyncMode;
    armedWr <= !(mrst || prst);
  end
  always_ff @(posedge rdClk) armedRd <= !(mrst || prst);

  AST_HF_REG: assert property (@(posedge wrClk) disable iff (mrst || prst)
    armedWr && !modeSeen |-> halfFull == ($past(wrLevel) > HALF_C)); // R4
  AST_HF_COMB: assert property (@(posedge wrClk) disable iff (mrst)
    modeSeen |-> halfFull == (wrLevel > HALF_C)); // R6
  AST_AF_AT_TOP: assert property (@(posedge wrClk) disable iff (mrst || prst)
    armedWr && !modeSeen && $past(wrLevel) == DEPTH_C |-> almostFull); // R3
  AST_AE_AT_ZERO: assert property (@(posedge rdClk) disable iff (mrst || prst)
    armedRd && !modeSeen && $past(rdLevel) == '0 |-> almostEmpty); // R2
  AST_AE_COMB_ZERO: assert property (@(posedge rdClk) disable iff (mrst)
    modeSeen && rdLevel == '0 |-> almostEmpty); // R6
endmodule

bind occ_flag_top occ_flag_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
  .wrClk(wrClk), .rdClk(rdClk), .mrst(mrst), .prst(prst),
  .asyncMode(asyncMode), .rdLevel(rdLevel), .wrLevel(wrLevel),
  .almostEmpty(almostEmpty), .almostFull(almostFull), .halfFull(halfFull)
);

// File: tb/test_occ_flag_top.sv
module test_occ_flag_top;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 256;
  localparam int CNT_W  = 9;
  localparam int OFF_W  = 8;

  // {level, expAE, expAF, expHF} with both margins at preset 15 (R1)
  localparam logic [11:0] VEC [8] = '{
    {9'd0,   3'b100}, {9'd15,  3'b100}, {9'd16, 3'b000}, {9'd128, 3'b000},
    {9'd129, 3'b001}, {9'd240, 3'b001}, {9'd241, 3'b011}, {9'd256, 3'b011}
  };

  logic clk = 1'b0;
  logic mrst, prst, asyncMode, loadEn, serEn, serIn;
  logic [2:0] presetSel;
  logic [CNT_W-1:0] lvl;
  logic [OFF_W-1:0] parData;
  logic ae, af, hf;
  int total = 0, bad = 0;
  bit doneFlag = 0;

  always #(PERIOD / 2) clk = ~clk;

  occ_flag_top #(.DEPTH(DEPTH)) i_occ_flag_top (
    .wrClk(clk), .rdClk(clk), .mrst(mrst), .prst(prst),
    .presetSel(presetSel), .asyncMode(asyncMode),
    .rdLevel(lvl), .wrLevel(lvl), .loadEn(loadEn), .serEn(serEn),
    .serIn(serIn), .parData(parData),
    .almostEmpty(ae), .almostFull(af), .halfFull(hf)
  );

  task automatic chk(string tag, logic [2:0] exp);
    total++;
    if ({ae, af, hf} !== exp) begin
      bad++;
      $display("FAIL %s: {ae,af,hf} actual=%b expected=%b", tag, {ae, af, hf}, exp);
    end
  endtask

  // drive level at negedge; registered mode samples after the next edge
  task automatic setLvl(input int l, input bit registered);
    @(negedge clk) lvl = CNT_W'(l);
    if (registered) @(negedge clk);
    else #2;
  endtask

  task automatic doReset(input bit am, input logic [2:0] sel);
    @(negedge clk);
    mrst = 1; asyncMode = am; presetSel = sel;
    repeat (3) @(negedge clk);
    mrst = 0;
  endtask

  task automatic parWr(input logic [7:0] v);
    @(negedge clk) loadEn = 1; serEn = 0; parData = v;
    @(negedge clk) loadEn = 0;
  endtask

  initial begin
    #(PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mrst = 1; prst = 0; asyncMode = 0; presetSel = 3; lvl = 100;
    loadEn = 0; serEn = 0; serIn = 0; parData = 0;
    repeat (3) @(negedge clk);
    chk("R5 reset value", 3'b100);
    mrst = 0;

    // R1/R2/R3/R4/R5: preset 15, registered mode, vector walk
    foreach (VEC[i]) begin
      setLvl(int'(VEC[i][11:3]), 1);
      chk($sformatf("R1 R2 R3 R4 R5 vec%0d", i), VEC[i][2:0]);
    end

    // R7: parallel load, empty=20 then full=30
    parWr(8'd20); parWr(8'd30);
    setLvl(20, 1);  chk("R7 empty margin 20 at", 3'b100);
    setLvl(21, 1);  chk("R7 empty margin 20 above", 3'b000);
    setLvl(226, 1); chk("R7 full margin 30 at", 3'b011);
    setLvl(225, 1); chk("R7 full margin 30 below", 3'b001);

    // R8: serial load, empty=5 then full=9, LSB first
    for (int b = 0; b < 2 * OFF_W; b++) begin
      @(negedge clk) loadEn = 1; serEn = 1;
      serIn = (b < OFF_W) ? (8'd5 >> b) & 1'b1 : (8'd9 >> (b - OFF_W)) & 1'b1;
    end
    @(negedge clk) loadEn = 0; serEn = 0;
    setLvl(5, 1);   chk("R8 serial empty 5 at", 3'b100);
    setLvl(6, 1);   chk("R8 serial empty 5 above", 3'b000);
    setLvl(247, 1); chk("R8 serial full 9 at", 3'b011);
    setLvl(246, 1); chk("R8 serial full 9 below", 3'b001);

    // R9: one parallel write (empty=40), partial reset, next write hits empty
    parWr(8'd40);
    @(negedge clk) prst = 1;
    @(negedge clk) chk("R9 R5 flags in partial reset", 3'b100);
    prst = 0;
    setLvl(40, 1); chk("R9 empty 40 kept", 3'b100);
    setLvl(41, 1); chk("R9 empty 40 kept above", 3'b000);
    parWr(8'd50);
    setLvl(50, 1);  chk("R9 sequence restarted at empty", 3'b100);
    setLvl(51, 1);  chk("R9 empty 50 above", 3'b000);
    setLvl(247, 1); chk("R9 full 9 kept", 3'b011);

    // R10: serial and parallel inputs toggled with loadEn low
    for (int b = 0; b < 2 * OFF_W; b++) begin
      @(negedge clk) serEn = b[0]; serIn = 1; parData = 8'hFF;
    end
    @(negedge clk) serEn = 0;
    setLvl(51, 1);  chk("R10 empty unchanged", 3'b000);
    setLvl(50, 1);  chk("R10 empty unchanged at", 3'b100);
    setLvl(246, 1); chk("R10 full unchanged", 3'b001);

    // R6: combinational mode, preset 1 (R1)
    doReset(1, 3'd0);
    setLvl(1, 0);   chk("R6 R1 comb empty 1 at", 3'b100);
    setLvl(2, 0);   chk("R6 comb empty 1 above", 3'b000);
    setLvl(129, 0); chk("R6 R4 comb half", 3'b001);
    setLvl(255, 0); chk("R6 comb full 1 at", 3'b011);
    setLvl(254, 0); chk("R6 comb full 1 below", 3'b001);

    // R1: preset 7 gives 255
    doReset(1, 3'd7);
    setLvl(255, 0); chk("R1 preset 255 empty", 3'b111);
    setLvl(1, 0);   chk("R1 preset 255 full", 3'b110);

    doneFlag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule